// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Matcher

This block picks which cells cross an N-by-N bufferless crossbar in one time slot of an input-queued switch that keeps a separate queue per input/output pair. The caller presents a flattened request bitmap and a start pulse. Bit `i*N+j` of the bitmap is set when input `i` holds a cell bound for output `j`. The block then refines a partial permutation over one or more iterations, one iteration per clock cycle.

In each iteration, every input and output that is still free takes part in three steps. First, each free input requests every free output it has a cell for. Second, each free output grants one requesting input. Third, each free input that received grants accepts one of them. Both the grant choice and the accept choice are round-robin: the candidate search starts at a per-port pointer. A pointer moves only when a pairing is formed in the first iteration of a slot. It then lands one position past the partner that was chosen. This is what spreads service evenly when the load is heavy.

The slot ends, and a one-cycle done strobe appears, after the configured number of iterations or as soon as an iteration adds no pairing. The match matrix is registered and holds its value until the next start.

Top module: `rr_xbar_matcher`

## Requirements
- R1: After reset, `match` is all zero, `done` is low, and every grant and accept pointer is at index 0.
- R2: Each row of `match` (bits `i*N` to `i*N+N-1`) and each column (bits `j`, `N+j`, ...) holds at most one set bit.
- R3: A bit of `match` is set only when the same bit of the request captured at start was set.
- R4: `done` is a single-cycle pulse. It rises 1 to L cycles after the clock edge that samples `start`. L is the effective limit: `iter_limit` 0 counts as 1, and values above N count as N.
- R5: A slot ends early as soon as an iteration adds no pairing. A slot that ends before L iterations therefore holds a maximal match. An empty request ends after one cycle with an empty match.
- R6: With an effective limit of N, the result is always maximal: no requested pair has both its input and its output left unpaired.
- R7: A free output grants the first requesting input found by searching upward from its grant pointer, with wrap. If that grant is accepted in the first iteration, the pointer moves to the granted input plus one, modulo N.
- R8: A free input accepts the first granting output found by searching upward from its accept pointer, with wrap. If this happens in the first iteration, the pointer moves to the accepted output plus one, modulo N.
- R9: Pairings formed in the second or later iterations of a slot leave every pointer unchanged.
- R10: Under all-ones requests with one iteration per slot, starting from reset, every slot from slot N onward is a full permutation. Over any N consecutive such slots, each input/output pair is served exactly once.
- R11: `match` does not change between `done` and the next start. A start that arrives while a slot is still running abandons that slot and begins a new one from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new slot; samples `req` and `iter_limit` |
| req | input | N*N | Request bitmap, bit `i*N+j` = input i has a cell for output j |
| iter_limit | input | $clog2(N+1) | Iteration budget for the slot (0 treated as 1, clamped to N) |
| match | output | N*N | Registered match matrix, same bit layout as `req` |
| done | output | 1 | One-cycle strobe: the slot's match is final |

## Verification
The iteration-budget exit and the no-progress exit can end a slot in the same cycle. This happens when the last allowed iteration is also the first one that adds nothing. The bench provokes it with a lone request at a budget of two, and with random budgets over random bitmaps. In each case it judges the outcome by the exact cycle of `done` and by whether the match is maximal. A second overlap is a first-iteration pointer update in the same cycle as a restarting start. The bench restarts a running slot and checks that the abandoned slot leaves no trace in the match.

// File: rtl/xm_pkg.sv
package xm_pkg;

  typedef enum logic {
    XM_IDLE = 1'b0,
    XM_RUN  = 1'b1
  } xm_state_e;

  // Index one step beyond idx on a ring of n ports.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/xm_rr_pick.sv
// Round-robin one-hot picker: first set request at or above ptr, with wrap.
module xm_rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);

  always_comb begin
    logic found;
    int   cand;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr) + k) % N;
      if (!found && req[cand]) begin
        found     = 1'b1;
        gnt[cand] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xm_grant_stage.sv
// One picker per output column; result bit i*N+j = output j grants input i.
module xm_grant_stage #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic [NN-1:0]   req_live,
  input  logic [N*PW-1:0] gptr,
  output logic [NN-1:0]   gnt_mat
);

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0] col_req;
    logic [N-1:0] col_gnt;
    for (genvar i = 0; i < N; i++) begin : g_in
      assign col_req[i]       = req_live[i*N+j];
      assign gnt_mat[i*N+j]   = col_gnt[i];
    end
    xm_rr_pick #(.N(N)) u_pick (
      .req(col_req),
      .ptr(gptr[j*PW +: PW]),
      .gnt(col_gnt)
    );
  end

endmodule

// File: rtl/xm_accept_stage.sv
// One picker per input row; picks one granting output per input.
module xm_accept_stage #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic [NN-1:0]   gnt_mat,
  input  logic [N*PW-1:0] aptr,
  output logic [NN-1:0]   new_match
);

  for (genvar i = 0; i < N; i++) begin : g_in
    xm_rr_pick #(.N(N)) u_pick (
      .req(gnt_mat[i*N +: N]),
      .ptr(aptr[i*PW +: PW]),
      .gnt(new_match[i*N +: N])
    );
  end

endmodule

// File: rtl/xm_ptr_bank.sv
// Grant pointers (one per output) and accept pointers (one per input).
module xm_ptr_bank #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [NN-1:0]   new_match,
  output logic [N*PW-1:0] gptr,
  output logic [N*PW-1:0] aptr
);

  logic [N*PW-1:0] gptr_nx;
  logic [N*PW-1:0] aptr_nx;

  always_comb begin
    gptr_nx = gptr;
    aptr_nx = aptr;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if (new_match[i*N+j]) begin
          gptr_nx[j*PW +: PW] = PW'(xm_pkg::ring_next(i, N));
          aptr_nx[i*PW +: PW] = PW'(xm_pkg::ring_next(j, N));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gptr <= '0;
      aptr <= '0;
    end else if (upd) begin
      gptr <= gptr_nx;
      aptr <= aptr_nx;
    end
  end

endmodule

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher #(
  parameter int N = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N*N-1:0]   req,
  input  logic [CW-1:0]    iter_limit,
  output logic [N*N-1:0]   match,
  output logic             done
);

  import xm_pkg::*;

  localparam int NN = N * N;
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  xm_state_e       st_q;
  logic [NN-1:0]   req_q;
  logic [NN-1:0]   match_q;
  logic [NN-1:0]   req_live;
  logic [NN-1:0]   gnt_mat;
  logic [NN-1:0]   new_match;
  logic [CW-1:0]   lim_q;
  logic [CW-1:0]   lim_eff;
  logic [CW-1:0]   it_q;
  logic [CW-1:0]   it_nx;
  logic            done_q;
  logic [N-1:0]    row_busy;
  logic [N-1:0]    col_busy;
  logic [N*PW-1:0] gptr;
  logic [N*PW-1:0] aptr;
  logic            run;
  logic            upd_en;

  // Ports already paired this slot drop out of later iterations.
  always_comb begin
    row_busy = '0;
    col_busy = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        row_busy[i] = row_busy[i] | match_q[i*N+j];
        col_busy[j] = col_busy[j] | match_q[i*N+j];
      end
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        req_live[i*N+j] = req_q[i*N+j] & ~row_busy[i] & ~col_busy[j];
      end
    end
  end

  always_comb begin
    if (iter_limit == '0)
      lim_eff = CW'(1);
    else if (iter_limit > CW'(N))
      lim_eff = CW'(N);
    else
      lim_eff = iter_limit;
  end

  assign run    = (st_q == XM_RUN);
  assign it_nx  = it_q + CW'(1);
  assign upd_en = run && (it_q == '0) && !start;

  xm_grant_stage #(.N(N)) u_grant (
    .req_live(req_live),
    .gptr    (gptr),
    .gnt_mat (gnt_mat)
  );

  xm_accept_stage #(.N(N)) u_accept (
    .gnt_mat  (gnt_mat),
    .aptr     (aptr),
    .new_match(new_match)
  );

  xm_ptr_bank #(.N(N)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_en),
    .new_match(new_match),
    .gptr     (gptr),
    .aptr     (aptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= XM_IDLE;
      req_q   <= '0;
      match_q <= '0;
      lim_q   <= CW'(1);
      it_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        st_q    <= XM_RUN;
        req_q   <= req;
        match_q <= '0;
        lim_q   <= lim_eff;
        it_q    <= '0;
      end else if (run) begin
        match_q <= match_q | new_match;
        it_q    <= it_nx;
        if ((new_match == '0) || (it_nx == lim_q)) begin
          st_q   <= XM_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign match = match_q;
  assign done  = done_q;

endmodule

// File: rtl/xm_checker.sv
module xm_checker #(
  parameter int N = 4,
  localparam int NN = N * N,
  localparam int KW = $clog2(N + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [NN-1:0] req,
  input logic [NN-1:0] match,
  input logic          done
);

  logic          busy_c;
  logic [KW-1:0] cnt;
  logic [NN-1:0] req_cap;
  logic [N-1:0]  col_v [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c  <= 1'b0;
      cnt     <= '0;
      req_cap <= '0;
    end else if (start) begin
      busy_c  <= 1'b1;
      cnt     <= '0;
      req_cap <= req;
    end else begin
      if (done) busy_c <= 1'b0;
      if (busy_c && cnt != KW'(N + 1)) cnt <= cnt + KW'(1);
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col_v[j][i] = match[i*N+j];
  end

  for (genvar r = 0; r < N; r++) begin : g_lines
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(match[r*N +: N])); // R2
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col_v[r])); // R2
  end

  AST_MATCH_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (match & ~req_cap) == '0); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_DONE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_c); // R4
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt >= KW'(1) && cnt <= KW'(N))); // R4
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_c && !start) |=> $stable(match)); // R11

endmodule

bind rr_xbar_matcher xm_checker #(.N(N)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .req  (req),
  .match(match),
  .done (done)
);

// File: tb/rr_xbar_matcher_bench.sv
module rr_xbar_matcher_bench;

  localparam int N  = 4;
  localparam int NN = N * N;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NN-1:0] req = '0;
  logic [CW-1:0] iter_limit = CW'(1);
  logic [NN-1:0] match;
  logic          done;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  always #10 clk = ~clk;

  rr_xbar_matcher #(.N(N)) u_rr_xbar_matcher (
    .clk(clk), .rst(rst), .start(start), .req(req),
    .iter_limit(iter_limit), .match(match), .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_perm(input logic [NN-1:0] m);
    for (int i = 0; i < N; i++) begin
      int rc = 0;
      int cc = 0;
      for (int j = 0; j < N; j++) begin
        rc += int'(m[i*N+j]);
        cc += int'(m[j*N+i]);
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit is_maximal(input logic [NN-1:0] m, input logic [NN-1:0] r);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        bit row_free = 1'b1;
        bit col_free = 1'b1;
        for (int k = 0; k < N; k++) begin
          if (m[i*N+k]) row_free = 1'b0;
          if (m[k*N+j]) col_free = 1'b0;
        end
        if (r[i*N+j] && row_free && col_free) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(match == '0 && done == 1'b0, "R1 reset state", {match, 3'b0, done}, 0);
  endtask

  // Run one slot; returns cycles from the start edge to done.
  task automatic run_slot(input logic [NN-1:0] r, input logic [CW-1:0] l, output int lat);
    int eff;
    eff = (l == 0) ? 1 : ((int'(l) > N) ? N : int'(l));
    @(negedge clk);
    req = r;
    iter_limit = l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat >= 1 && lat <= eff, "R4 done latency", lat, eff);
    check(is_perm(match), "R2 partial permutation", match, 0);
    check((match & ~r) == '0, "R3 match within request", match, r);
    if (lat < eff)
      check(is_maximal(match, r), "R5 early exit maximal", match, r);
    if (eff == N)
      check(is_maximal(match, r), "R6 maximal at N iterations", match, r);
    @(negedge clk);
    check(done == 1'b0, "R4 done single pulse", done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errs++;
        vecs++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    int pair_cnt [NN];
    logic [NN-1:0] held;

    do_reset();

    // Budget 0 acts as 1: only the first-iteration pair forms (R4, R7, R8).
    run_slot(16'h0023, CW'(0), lat);
    check(lat == 1, "R4 zero budget as one", lat, 1);
    check(match == 16'h0001, "R7 R8 first pick from pointer 0", match, 16'h0001);

    // Second-iteration pair must not move pointers (R9), then all-ones fairness (R10).
    do_reset();
    run_slot(16'h0023, CW'(2), lat);
    check(lat == 2, "R9 second iteration used", lat, 2);
    check(match == 16'h0021, "R9 second iteration pair", match, 16'h0021);
    run_slot(16'hFFFF, CW'(1), lat);
    check(match == 16'h0012, "R9 R7 pointers after late pair", match, 16'h0012);
    run_slot(16'hFFFF, CW'(1), lat);
    check(match == 16'h0124, "R8 accept pointer advance", match, 16'h0124);
    for (int p = 0; p < NN; p++) pair_cnt[p] = 0;
    for (int s = 0; s < N; s++) begin
      run_slot(16'hFFFF, CW'(1), lat);
      if (s == 0) check(match == 16'h1248, "R10 first full slot", match, 16'h1248);
      check($countones(match) == N, "R10 full permutation", $countones(match), N);
      for (int p = 0; p < NN; p++) pair_cnt[p] += int'(match[p]);
    end
    for (int p = 0; p < NN; p++)
      check(pair_cnt[p] == 1, "R10 each pair once per N slots", pair_cnt[p], 1);

    // Lone request: no-progress and budget exits coincide, or early exit (R5).
    run_slot(16'h0800, CW'(2), lat);
    check(lat == 2 && match == 16'h0800, "R5 lone pair at budget 2", {lat, match}, {32'd2, 16'h0800});
    run_slot(16'h0800, CW'(4), lat);
    check(lat == 2 && match == 16'h0800, "R5 lone pair early exit", {lat, match}, {32'd2, 16'h0800});
    run_slot(16'h0000, CW'(4), lat);
    check(lat == 1 && match == '0, "R5 empty request", {lat, match}, {32'd1, 16'h0});

    // Budget above N clamps to N (R4, R6).
    run_slot(16'hFFFF, CW'(7), lat);
    check($countones(match) == N, "R6 clamped budget full match", $countones(match), N);

    // Restart while running (R11).
    @(negedge clk);
    req = 16'hFFFF;
    iter_limit = CW'(4);
    start = 1'b1;
    @(negedge clk);
    req = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 1 && match == '0, "R11 restart drops old slot", {lat, match}, {32'd1, 16'h0});

    // Random sweep over bitmaps and budgets.
    for (int t = 0; t < 400; t++) begin
      logic [NN-1:0] r;
      r = NN'($urandom) & NN'($urandom | ((t % 3 == 0) ? 32'hFFFF : 32'h0));
      run_slot(r, CW'($urandom_range(0, 7)), lat);
    end

    // Hold after done (R11).
    run_slot(16'h8421, CW'(4), lat);
    held = match;
    @(negedge clk);
    req = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(match == held, "R11 match holds without start", match, held);
    check(held == 16'h8421, "R6 disjoint pairs all matched", held, 16'h8421);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule